// File: doc/BRIEF.md
# Saturating Bidirectional Arithmetic Shifter

This block shifts a signed fixed-point word by a signed amount. The same unit serves left and right shifts: the opcode picks a nominal direction, and a negative amount turns that direction around and shifts by the magnitude. Right shifts are arithmetic, so the sign is copied in from the top. Left shifts clamp to the most positive or most negative value the word can hold and raise a saturation flag. A rounding variant of the right shift adds back the last bit that was shifted out.

Two word widths are served by one instance. In wide mode the full 32-bit operand is used. In narrow mode only the low 16 bits count, and the result comes back sign-extended to 32 bits. A `valid` strobe loads the output register, and `out_valid` follows one cycle later. The unit fits into a DSP datapath as a normalisation or scaling stage, between a multiplier or accumulator and the next stage.

Top module: `sat_shifter`

## Requirements
- R1: Opcode 0 shifts left, opcode 1 shifts right, opcode 2 is the rounded right shift, and opcode 3 behaves like opcode 1. When the amount is positive and in range, the result is the operand shifted the stated way.
- R2: A negative amount shifts by its magnitude in the opposite direction. Under opcode 2 the shift then becomes a plain saturating left shift. An amount of -32768 is handled as a magnitude of 32768.
- R3: Right shifts fill with the sign. With a word width of W (16 or 32), a plain right shift by W-1 or more gives -1 for a negative operand and 0 otherwise.
- R4: Narrow mode, left shift:
  - When the shifted value does not fit in 16 signed bits, the result saturates to 0x7FFF for a non-negative operand and to 0x8000 for a negative one.
  - Any amount of 16 or more with a nonzero operand saturates.
  - A zero operand always gives 0.
- R5: Wide mode, left shift: a result that leaves the signed 32-bit range saturates to 0x7FFFFFFF or 0x80000000, following the sign of the operand.
- R6: Rounded right shift (opcode 2 with a non-negative amount k):
  - The result is 0 when k > W-1.
  - Otherwise it is the arithmetic shift by k, plus 1 when operand bit k-1 is set (k > 0).
- R7: `sat_flag` is high with exactly those results that were clamped by R4 or R5, and low with every other result.
- R8: A zero amount returns the operand unchanged under every opcode and in both modes.
- R9: Reset clears `result`, `sat_flag` and `out_valid`. The output register loads only in a cycle where `in_valid` is high, and `out_valid` is high in the cycle after each such load and low otherwise.
- R10: In narrow mode, bits 31..16 of the operand have no effect, and `result` is the 16-bit answer sign-extended to 32 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Loads the output register with this cycle's answer |
| wide_mode | input | 1 | 1 = 32-bit word, 0 = 16-bit word in the low half |
| opcode | input | 2 | 0 left, 1 right, 2 rounded right, 3 right |
| operand | input | 32 | Signed operand |
| amount | input | 16 | Signed shift amount |
| out_valid | output | 1 | Result loaded in the previous cycle |
| result | output | 32 | Shifted, clamped or rounded word |
| sat_flag | output | 1 | Result was clamped |

## Verification
The hard corners are at the range limits: a left shift that lands exactly on the edge of the signed range, a right shift by exactly W-1 compared with W, and rounding when bit k-1 is the sign bit. The amount -32768 is another, because its magnitude does not fit in the amount width. A sweep covers all of these. It takes amounts from -40 to 40 together with both 16-bit extremes, a set of operands placed at the signed limits and the powers of two next to them, all four opcodes and both modes. In narrow mode the upper operand bits carry a junk pattern, so any leakage from them would show up in the result.

// File: rtl/sft_pkg.sv
package sft_pkg;
  typedef enum logic [1:0] {
    SFT_LEFT  = 2'd0,
    SFT_RIGHT = 2'd1,
    SFT_RRND  = 2'd2,
    SFT_RALT  = 2'd3
  } sft_op_e;
endpackage

// File: rtl/sft_amt_dec.sv
module sft_amt_dec #(
  parameter int AMT_W = 16
) (
  input  logic [1:0]       opcode,
  input  logic [AMT_W-1:0] amount,
  output logic             go_left,
  output logic             do_round,
  output logic [AMT_W:0]   mag
);
  import sft_pkg::*;
  logic          neg;
  logic [AMT_W:0] ext;

  assign neg      = amount[AMT_W-1];
  assign ext      = {amount[AMT_W-1], amount};
  assign mag      = neg ? (~ext + 1'b1) : ext;
  assign go_left  = (sft_op_e'(opcode) == SFT_LEFT) ^ neg;
  assign do_round = (sft_op_e'(opcode) == SFT_RRND) && !neg;
endmodule

// File: rtl/sft_lane.sv
module sft_lane #(
  parameter int W     = 16,
  parameter int MAG_W = 17
) (
  input  logic [W-1:0]     opnd,
  input  logic             go_left,
  input  logic             do_round,
  input  logic [MAG_W-1:0] mag,
  output logic [W-1:0]     res,
  output logic             clamped
);
  localparam int LW = $clog2(W);

  logic                  big_l, big_r, past_rnd, nonzero, fits, rbit;
  logic [LW-1:0]         k, km1;
  logic signed [2*W-1:0] ext, shl;
  logic [W:0]            top_bits;
  logic [W-1:0]          limit, fill, asr;

  assign big_l    = mag >= MAG_W'(W);
  assign big_r    = mag >= MAG_W'(W - 1);
  assign past_rnd = mag >  MAG_W'(W - 1);
  assign k        = mag[LW-1:0];
  assign km1      = k - 1'b1;
  assign ext      = {{W{opnd[W-1]}}, opnd};
  assign shl      = ext <<< k;
  assign top_bits = shl[2*W-1:W-1];
  assign fits     = (&top_bits) | (~|top_bits);
  assign nonzero  = |opnd;
  assign limit    = opnd[W-1] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
  assign fill     = {W{opnd[W-1]}};
  assign asr      = W'($signed(opnd) >>> k);
  assign rbit     = (k != '0) && opnd[km1];

  always_comb begin
    clamped = 1'b0;
    if (go_left) begin
      if (!nonzero) begin
        res = '0;
      end else if (big_l || !fits) begin
        res     = limit;
        clamped = 1'b1;
      end else begin
        res = shl[W-1:0];
      end
    end else if (do_round) begin
      if (past_rnd) res = '0;
      else          res = (big_r ? fill : asr) + W'(rbit);
    end else begin
      res = big_r ? fill : asr;
    end
  end
endmodule

// File: rtl/sat_shifter.sv
module sat_shifter #(
  parameter int WIDE_W   = 32,
  parameter int NARROW_W = 16,
  parameter int AMT_W    = 16,
  parameter bit REG_OUT  = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              wide_mode,
  input  logic [1:0]        opcode,
  input  logic [WIDE_W-1:0] operand,
  input  logic [AMT_W-1:0]  amount,
  output logic              out_valid,
  output logic [WIDE_W-1:0] result,
  output logic              sat_flag
);
  localparam int MAG_W = AMT_W + 1;

  logic                go_left, do_round;
  logic [MAG_W-1:0]    mag;
  logic [NARROW_W-1:0] n_res;
  logic [WIDE_W-1:0]   w_res, c_res;
  logic                n_clamp, w_clamp, c_clamp;

  sft_amt_dec #(.AMT_W(AMT_W)) u_dec (
    .opcode(opcode), .amount(amount),
    .go_left(go_left), .do_round(do_round), .mag(mag)
  );

  sft_lane #(.W(NARROW_W), .MAG_W(MAG_W)) u_narrow (
    .opnd(operand[NARROW_W-1:0]), .go_left(go_left), .do_round(do_round),
    .mag(mag), .res(n_res), .clamped(n_clamp)
  );

  sft_lane #(.W(WIDE_W), .MAG_W(MAG_W)) u_wide (
    .opnd(operand), .go_left(go_left), .do_round(do_round),
    .mag(mag), .res(w_res), .clamped(w_clamp)
  );

  assign c_res   = wide_mode ? w_res : {{(WIDE_W-NARROW_W){n_res[NARROW_W-1]}}, n_res};
  assign c_clamp = wide_mode ? w_clamp : n_clamp;

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          out_valid <= 1'b0;
          result    <= '0;
          sat_flag  <= 1'b0;
        end else begin
          out_valid <= in_valid;
          if (in_valid) begin
            result   <= c_res;
            sat_flag <= c_clamp;
          end
        end
      end
    end else begin : g_comb
      assign out_valid = in_valid;
      assign result    = c_res;
      assign sat_flag  = c_clamp;
    end
  endgenerate
endmodule

// File: rtl/sat_shifter_chk.sv
module sat_shifter_chk #(
  parameter int WIDE_W   = 32,
  parameter int NARROW_W = 16,
  parameter int AMT_W    = 16,
  parameter bit REG_OUT  = 1'b1
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              wide_mode,
  input logic [1:0]        opcode,
  input logic [WIDE_W-1:0] operand,
  input logic [AMT_W-1:0]  amount,
  input logic              out_valid,
  input logic [WIDE_W-1:0] result,
  input logic              sat_flag
);
  localparam logic [WIDE_W-1:0] W_MAX = {1'b0, {(WIDE_W-1){1'b1}}};
  localparam logic [WIDE_W-1:0] W_MIN = {1'b1, {(WIDE_W-1){1'b0}}};
  localparam logic [WIDE_W-1:0] N_MAX = WIDE_W'({1'b0, {(NARROW_W-1){1'b1}}});
  localparam logic [WIDE_W-1:0] N_MIN = {{(WIDE_W-NARROW_W+1){1'b1}}, {(NARROW_W-1){1'b0}}};

  generate
    if (REG_OUT) begin : g_chk
      a_r9_valid_rise: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
      a_r9_valid_low: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
      a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(result) && $stable(sat_flag)));
      a_r7_clamp_value: assert property (@(posedge clk) disable iff (rst)
        (out_valid && sat_flag) |->
          (result == W_MAX || result == W_MIN || result == N_MAX || result == N_MIN));
      a_r10_narrow_ext: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !$past(wide_mode)) |->
          ((&result[WIDE_W-1:NARROW_W-1]) || !(|result[WIDE_W-1:NARROW_W-1])));
      a_r8_zero_pass: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(wide_mode) && $past(amount) == '0) |->
          (result == $past(operand) && !sat_flag));
      a_r6_round_far: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(wide_mode) && $past(opcode) == 2'd2 &&
         !$past(amount[AMT_W-1]) && $past(amount) > AMT_W'(WIDE_W - 1)) |->
          (result == '0 && !sat_flag));
    end
  endgenerate
endmodule

bind sat_shifter sat_shifter_chk #(
  .WIDE_W(WIDE_W), .NARROW_W(NARROW_W), .AMT_W(AMT_W), .REG_OUT(REG_OUT)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .wide_mode(wide_mode),
  .opcode(opcode), .operand(operand), .amount(amount),
  .out_valid(out_valid), .result(result), .sat_flag(sat_flag)
);

// File: tb/sim_sat_shifter.sv
`timescale 1ns/1ps
module sim_sat_shifter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        wide_mode = 1'b0;
  logic [1:0]  opcode = 2'd0;
  logic [31:0] operand = '0;
  logic [15:0] amount = '0;
  logic        out_valid;
  logic [31:0] result;
  logic        sat_flag;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  sat_shifter u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .wide_mode(wide_mode),
    .opcode(opcode), .operand(operand), .amount(amount),
    .out_valid(out_valid), .result(result), .sat_flag(sat_flag)
  );

  // Reference: iterative doubling with range tests, floor-halving for right.
  function automatic logic [32:0] model(input bit wm, input logic [1:0] op,
                                        input logic [31:0] opr, input logic [15:0] am);
    int     w;
    longint v, hi, lo, r;
    int     a, m;
    bit     left;
    w  = wm ? 32 : 16;
    v  = wm ? longint'($signed(opr)) : longint'($signed(opr[15:0]));
    hi = (longint'(1) <<< (w - 1)) - 1;
    lo = -(longint'(1) <<< (w - 1));
    a  = int'($signed(am));
    if (op == 2'd2 && a >= 0) begin
      if (a > w - 1) return 33'd0;
      r = v >>> a;
      if (a > 0 && v[a-1]) r = r + 1;
      return {1'b0, 32'(r)};
    end
    left = (op == 2'd0) ^ (a < 0);
    m    = (a < 0) ? -a : a;
    if (left) begin
      for (int i = 0; i < m; i++) begin
        if (v == 0) break;
        if (v > hi / 2) return {1'b1, 32'(hi)};
        if (v < lo / 2) return {1'b1, 32'(lo)};
        v = v * 2;
      end
      return {1'b0, 32'(v)};
    end
    r = v >>> ((m > 63) ? 63 : m);
    return {1'b0, 32'(r)};
  endfunction

  function automatic string tag_of(input bit wm, input logic [1:0] op, input logic [15:0] am);
    int    a;
    string t;
    a = int'($signed(am));
    if (a == 0)                            t = "R8";
    else if (a < 0)                        t = "R2";
    else if (op == 2'd2)                   t = "R6";
    else if (op == 2'd0)                   t = wm ? "R5" : "R4";
    else if (a >= (wm ? 31 : 15))          t = "R3";
    else                                   t = "R1";
    return wm ? t : {"R10/", t};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input bit wm, input logic [1:0] op, input logic [31:0] opr,
                       input logic [15:0] am);
    logic [32:0] e;
    string       t;
    @(negedge clk);
    wide_mode = wm; opcode = op; operand = opr; amount = am; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    e = model(wm, op, opr, am);
    t = tag_of(wm, op, am);
    check(result == e[31:0], t, result, e[31:0]);
    check(sat_flag == e[32], "R7 sat_flag", 32'(sat_flag), 32'(e[32]));
    check(out_valid == 1'b1, "R9 out_valid", 32'(out_valid), 32'd1);
  endtask

  localparam logic [15:0] N_OPS [12] = '{16'h0000, 16'h0001, 16'hFFFF, 16'h7FFF,
    16'h8000, 16'h4000, 16'hC000, 16'h1234, 16'hFFFD, 16'h0005, 16'h3FFF, 16'hC001};
  localparam logic [31:0] W_OPS [12] = '{32'h0, 32'h1, 32'hFFFFFFFF, 32'h7FFFFFFF,
    32'h80000000, 32'h40000000, 32'hC0000000, 32'h00012345, 32'hFFFEDCBA,
    32'h3FFFFFFF, 32'hC0000001, 32'h0000FFFF};

  initial begin
    logic [31:0] held;
    repeat (3) @(negedge clk);
    check(result == 32'd0 && sat_flag == 1'b0 && out_valid == 1'b0, "R9 reset",
          result, 32'd0);
    rst = 1'b0;

    for (int md = 0; md < 2; md++)
      for (int oi = 0; oi < 12; oi++)
        for (int op = 0; op < 4; op++) begin
          for (int a = -40; a <= 40; a++)
            apply(md[0], 2'(op), md[0] ? W_OPS[oi] : {16'hA5C3, N_OPS[oi]}, 16'(a));
          apply(md[0], 2'(op), md[0] ? W_OPS[oi] : {16'h5A3C, N_OPS[oi]}, 16'h8000);
          apply(md[0], 2'(op), md[0] ? W_OPS[oi] : {16'h5A3C, N_OPS[oi]}, 16'h7FFF);
        end

    // R9: in_valid low leaves the register untouched and drops out_valid.
    apply(1'b1, 2'd0, 32'h00000123, 16'd4);
    held = result;
    @(negedge clk);
    wide_mode = 1'b1; opcode = 2'd1; operand = 32'h7FFF0000; amount = 16'd3; in_valid = 1'b0;
    @(negedge clk);
    check(result == held, "R9 hold", result, held);
    check(out_valid == 1'b0, "R9 no valid", 32'(out_valid), 32'd0);
    check(sat_flag == 1'b0, "R9 flag hold", 32'(sat_flag), 32'd0);

    // R10: narrow result unaffected by different upper bits.
    apply(1'b0, 2'd0, 32'hFFFF0123, 16'd3);
    held = result;
    apply(1'b0, 2'd0, 32'h00000123, 16'd3);
    check(result == held && result == 32'h00000918, "R10 upper bits", result, 32'h00000918);

    done = 1'b1;
  end

  initial begin
    fork
      begin : wd
        repeat (190000) @(posedge clk);
        if (!done) begin
          checks++;
          fails++;
          $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        end
      end
      begin
        wait (done);
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule